// File: doc/BRIEF.md
# Display Register Window Decoder

This block sits between a simple host bus and the register groups of a display controller. A host access names a byte offset inside a 4 KiB register window. The block finds which group owns that offset and routes the access there.

There are four groups. The first is a read-only identification ROM at the bottom of the window. The second is a block of byte-wide legacy display ports. The third is a file of 16-bit mode registers, reached by direct offset. The fourth is a small extension group that reports its own size and holds the framebuffer byte-order flag. The ROM and the extension group each have their own enable parameter.

Every access takes one bus cycle. A read returns its data through a registered valid pulse. When the host writes a 16-bit word into the legacy area, the block breaks it into two byte writes, low byte first. This lets an index port and its data port be loaded with a single host write.

Top module: `disp_mmio_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `h_rvalid` is 0 and `fb_big_endian` is 0 (little-endian). After reset, no port, mode-register or ROM strobe is active unless the host makes an access.
- R2: A cycle with `h_rd` high is followed by exactly one cycle with `h_rvalid` high, and `h_rdata` carries the read result in that cycle. Write and idle cycles are followed by `h_rvalid` low.
- R3: The legacy area covers host offsets 0x400–0x41F. A 1-byte access at 0x400+N drives `lp_addr` = 0x3C0+N. A write puts `h_wdata[7:0]` on the port, and a read returns `lp_rdata_lo` in `h_rdata[7:0]`. The size codes on `h_size` are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A legacy access of 4 bytes or of size code 3 reads zero and drives no port strobe.
- R4: A 2-byte legacy write at 0x400+N writes `h_wdata[7:0]` to port 0x3C0+N in the access cycle. It then writes `h_wdata[15:0]`'s upper byte to port 0x3C1+N in the next cycle. The host leaves at least one idle cycle after each access.
- R5: A 2-byte legacy read at 0x400+N returns port 0x3C0+N in bits 7:0 and port 0x3C1+N in bits 15:8. The port 0x3C1+N byte arrives on `lp_rdata_hi`.
- R6: The mode registers cover offsets 0x500–0x517. An access at offset 0x500+K selects register index K>>1 on `mr_index`. A write of any size stores `h_wdata[15:0]`. A read of any size returns the 16-bit register, zero-extended.
- R7: A 4-byte read at extension offset 0x600 returns the extension group size, 8.
- R8: A 4-byte write of 0xBEBEBEBE at 0x604 sets `fb_big_endian`. A 4-byte write of 0x1E1E1E1E at 0x604 clears it. Any other written value leaves it unchanged. A 4-byte read at 0x604 returns 0xBEBEBEBE when the flag is set and 0x1E1E1E1E when it is clear.
- R9: The extension group acts only on 4-byte accesses at offsets 0x600 and 0x604. Any other size or offset inside 0x600–0x607 reads zero, and a write there leaves `fb_big_endian` unchanged.
- R10: The ROM covers offsets 0x000–0x3FF. A read drives `rom_addr` with the offset. It returns `rom_rdata` masked to the access size: 8, 16 or 32 bits, and zero for size code 3. Host writes there change nothing.
- R11: An offset outside every decoded area, such as 0x480 or 0x700, reads zero and raises no port or mode-register strobe.
- R12: `revision` is 2 when the extension group is enabled and `BASE_REV` (default 1) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 12 | Byte offset in the register window |
| h_size | input | 2 | Access size code: 0=1 byte, 1=2 bytes, 2=4 bytes |
| h_rd | input | 1 | Read strobe, one cycle |
| h_wr | input | 1 | Write strobe, one cycle |
| h_wdata | input | 32 | Write data |
| h_rdata | output | 32 | Registered read data |
| h_rvalid | output | 1 | Read data valid pulse |
| lp_addr | output | 10 | Legacy port address |
| lp_wr | output | 1 | Legacy port byte write strobe |
| lp_rd | output | 1 | Legacy port read strobe |
| lp_wdata | output | 8 | Legacy port write byte |
| lp_rdata_lo | input | 8 | Byte at port `lp_addr` |
| lp_rdata_hi | input | 8 | Byte at port `lp_addr`+1 |
| mr_index | output | 4 | Mode register index |
| mr_wr | output | 1 | Mode register write strobe |
| mr_rd | output | 1 | Mode register read strobe |
| mr_wdata | output | 16 | Mode register write data |
| mr_rdata | input | 16 | Mode register read data |
| rom_addr | output | 10 | ROM byte address |
| rom_rdata | input | 32 | Four ROM bytes starting at `rom_addr`, lowest in bits 7:0 |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| revision | output | 8 | Reported device revision |

## Verification
The assertions check several rules on every cycle:
- a read pulse always produces exactly one valid pulse;
- the second half of a split legacy write lands on the next port address in the very next cycle;
- port strobes never leave the legacy port range;
- unmapped offsets return zero with no strobes;
- the byte-order flag holds through odd values and wrong-sized writes.

Other behaviour shows up only in the bench scenarios:
- that data actually reaches the right port or register and reads back intact;
- the exact byte order of word reads;
- the ROM masking;
- the two code values of the byte-order register.

// File: rtl/disp_mmio_pkg.sv
// Package: shared types for the display register window decoder.
// Holds the region select enumeration and the host access size codes.
package disp_mmio_pkg;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_ROM  = 3'd1,
        RG_LEG  = 3'd2,
        RG_MODE = 3'd3,
        RG_EXT  = 3'd4
    } region_e;

    localparam logic [1:0] SZ_1 = 2'd0;
    localparam logic [1:0] SZ_2 = 2'd1;
    localparam logic [1:0] SZ_4 = 2'd2;

endpackage

// File: rtl/dmw_region_decode.sv
// Module: dmw_region_decode
// Turns a window byte offset into a region select and an offset that is
// relative to the base of that region. Purely combinational.
// Assumes the regions do not overlap. A disabled region decodes as RG_NONE.
module dmw_region_decode
    import disp_mmio_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit ROM_EN    = 1'b1,
    parameter bit EXT_EN    = 1'b1,
    parameter int ROM_SIZE  = 1024,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_SIZE  = 32,
    parameter int MODE_BASE = 'h500,
    parameter int MODE_SIZE = 24,
    parameter int EXT_BASE  = 'h600,
    parameter int EXT_SIZE  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);

    localparam int AW1 = ADDR_W + 1;
    localparam logic [AW1-1:0] ROM_HI  = AW1'(ROM_SIZE);
    localparam logic [AW1-1:0] LEG_LO  = AW1'(LEG_BASE);
    localparam logic [AW1-1:0] LEG_HI  = AW1'(LEG_BASE + LEG_SIZE);
    localparam logic [AW1-1:0] MODE_LO = AW1'(MODE_BASE);
    localparam logic [AW1-1:0] MODE_HI = AW1'(MODE_BASE + MODE_SIZE);
    localparam logic [AW1-1:0] EXT_LO  = AW1'(EXT_BASE);
    localparam logic [AW1-1:0] EXT_HI  = AW1'(EXT_BASE + EXT_SIZE);

    logic [AW1-1:0] a_ext;
    assign a_ext = {1'b0, addr};

    // Region match and base subtraction.
    always_comb begin
        region = RG_NONE;
        offset = '0;
        if (ROM_EN && (a_ext < ROM_HI)) begin
            region = RG_ROM;
            offset = addr;
        end else if ((a_ext >= LEG_LO) && (a_ext < LEG_HI)) begin
            region = RG_LEG;
            offset = addr - ADDR_W'(LEG_BASE);
        end else if ((a_ext >= MODE_LO) && (a_ext < MODE_HI)) begin
            region = RG_MODE;
            offset = addr - ADDR_W'(MODE_BASE);
        end else if (EXT_EN && (a_ext >= EXT_LO) && (a_ext < EXT_HI)) begin
            region = RG_EXT;
            offset = addr - ADDR_W'(EXT_BASE);
        end
    end

endmodule

// File: rtl/dmw_legacy_bridge.sv
// Module: dmw_legacy_bridge
// Maps the legacy area onto byte-wide display ports.
// A 2-byte write becomes two port writes: the low byte goes out in the
// access cycle and the high byte to the next port in the following cycle.
// A 2-byte read takes both bytes at once from the port side.
// Assumes the host leaves one idle cycle after each access, so that a
// pending high byte never meets a new request.
module dmw_legacy_bridge
    import disp_mmio_pkg::*;
#(
    parameter int                  LEG_AW    = 5,
    parameter int                  PORT_W    = 10,
    parameter logic [PORT_W-1:0]   PORT_BASE = 10'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [1:0]        h_size,
    input  logic [LEG_AW-1:0] ofs,
    input  logic [15:0]       wdata,
    output logic [PORT_W-1:0] lp_addr,
    output logic              lp_wr,
    output logic              lp_rd,
    output logic [7:0]        lp_wdata,
    input  logic [7:0]        lp_rdata_lo,
    input  logic [7:0]        lp_rdata_hi,
    output logic [15:0]       rdata
);

    localparam logic [PORT_W-1:0] PORT_TOP = PORT_BASE + PORT_W'(1 << LEG_AW);

    logic              acc_ok;
    logic              pend_q;
    logic [PORT_W-1:0] pend_addr_q;
    logic [7:0]        pend_data_q;
    logic [PORT_W-1:0] base_addr;

    assign acc_ok    = sel && ((h_size == SZ_1) || (h_size == SZ_2));
    assign base_addr = PORT_BASE + PORT_W'(ofs);

    // Hold the high byte of a split write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else begin
            pend_q      <= !pend_q && acc_ok && h_wr && (h_size == SZ_2);
            pend_addr_q <= base_addr + PORT_W'(1);
            pend_data_q <= wdata[15:8];
        end
    end

    // Port strobes: a pending high byte takes precedence over a new request.
    always_comb begin
        lp_addr  = pend_q ? pend_addr_q : base_addr;
        lp_wdata = pend_q ? pend_data_q : wdata[7:0];
        lp_wr    = pend_q || (acc_ok && h_wr);
        lp_rd    = !pend_q && acc_ok && h_rd;
    end

    // Read data assembly, low port in the low byte.
    always_comb begin
        rdata = '0;
        if (acc_ok) begin
            rdata = (h_size == SZ_2) ? {lp_rdata_hi, lp_rdata_lo} : {8'h00, lp_rdata_lo};
        end
    end

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && acc_ok && h_wr && (h_size == SZ_2)) |=> (lp_wr && (lp_addr == $past(lp_addr) + PORT_W'(1)))) // R4
        else $error("high byte did not follow low byte");

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_wr || lp_rd) |-> ((lp_addr >= PORT_BASE) && (lp_addr <= PORT_TOP))) // R3
        else $error("legacy port strobe outside port range");

endmodule

// File: rtl/dmw_ext_regs.sv
// Module: dmw_ext_regs
// Extension group: a read-only size register and the byte-order register.
// Only 4-byte accesses act. The flag changes only on an exact code match.
// Undefined offsets read zero.
module dmw_ext_regs
    import disp_mmio_pkg::*;
#(
    parameter int          EXT_AW   = 3,
    parameter logic [31:0] SIZE_VAL = 32'd8,
    parameter logic [31:0] BE_CODE  = 32'hBEBE_BEBE,
    parameter logic [31:0] LE_CODE  = 32'h1E1E_1E1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              h_wr,
    input  logic [1:0]        h_size,
    input  logic [EXT_AW-1:0] ofs,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              fb_big_endian
);

    localparam logic [EXT_AW-1:0] OFS_SIZE  = EXT_AW'(0);
    localparam logic [EXT_AW-1:0] OFS_ORDER = EXT_AW'(4);

    logic ok4;
    assign ok4 = sel && (h_size == SZ_4);

    // Byte-order flag update on an exact code match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_big_endian <= 1'b0;
        end else if (ok4 && h_wr && (ofs == OFS_ORDER)) begin
            if (wdata == BE_CODE) begin
                fb_big_endian <= 1'b1;
            end else if (wdata == LE_CODE) begin
                fb_big_endian <= 1'b0;
            end
        end
    end

    // Read mux for the two defined registers.
    always_comb begin
        rdata = '0;
        if (ok4 && (ofs == OFS_SIZE)) begin
            rdata = SIZE_VAL;
        end else if (ok4 && (ofs == OFS_ORDER)) begin
            rdata = fb_big_endian ? BE_CODE : LE_CODE;
        end
    end

    AST_ODD_VALUE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && h_wr && (wdata != BE_CODE) && (wdata != LE_CODE)) |=> $stable(fb_big_endian)) // R8
        else $error("flag moved on a non-code value");

    AST_BE_CODE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ok4 && h_wr && (ofs == OFS_ORDER) && (wdata == BE_CODE)) |=> fb_big_endian) // R8
        else $error("big-endian code did not set flag");

    AST_SIZE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && h_wr && (h_size != SZ_4)) |=> $stable(fb_big_endian)) // R9
        else $error("flag moved on a non-4-byte write");

endmodule

// File: rtl/disp_mmio_decoder.sv
// Module: disp_mmio_decoder
// Register window decoder for a display controller. It decodes the host
// offset, routes the access to the ROM, legacy ports, mode registers or
// extension group, and returns read data through a registered valid pulse.
// Assumes at most one of h_rd/h_wr per cycle and one idle cycle after
// every access.
module disp_mmio_decoder
    import disp_mmio_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter bit          ROM_EN    = 1'b1,
    parameter bit          EXT_EN    = 1'b1,
    parameter int          ROM_SIZE  = 1024,
    parameter int          LEG_BASE  = 'h400,
    parameter int          LEG_SIZE  = 32,
    parameter int          MODE_BASE = 'h500,
    parameter int          MODE_SIZE = 24,
    parameter int          EXT_BASE  = 'h600,
    parameter int          EXT_SIZE  = 8,
    parameter logic [9:0]  PORT_BASE = 10'h3C0,
    parameter logic [31:0] BE_CODE   = 32'hBEBE_BEBE,
    parameter logic [31:0] LE_CODE   = 32'h1E1E_1E1E,
    parameter logic [7:0]  BASE_REV  = 8'd1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [11:0]  h_addr,
    input  logic [1:0]   h_size,
    input  logic         h_rd,
    input  logic         h_wr,
    input  logic [31:0]  h_wdata,
    output logic [31:0]  h_rdata,
    output logic         h_rvalid,
    output logic [9:0]   lp_addr,
    output logic         lp_wr,
    output logic         lp_rd,
    output logic [7:0]   lp_wdata,
    input  logic [7:0]   lp_rdata_lo,
    input  logic [7:0]   lp_rdata_hi,
    output logic [3:0]   mr_index,
    output logic         mr_wr,
    output logic         mr_rd,
    output logic [15:0]  mr_wdata,
    input  logic [15:0]  mr_rdata,
    output logic [9:0]   rom_addr,
    input  logic [31:0]  rom_rdata,
    output logic         fb_big_endian,
    output logic [7:0]   revision
);

    localparam int ROM_AW = $clog2(ROM_SIZE);
    localparam int LEG_AW = $clog2(LEG_SIZE);
    localparam int MIDX_W = $clog2(MODE_SIZE / 2);
    localparam int EXT_AW = $clog2(EXT_SIZE);
    localparam int PORT_W = 10;

    region_e           region;
    logic [ADDR_W-1:0] offset;
    logic [15:0]       leg_rdata;
    logic [31:0]       ext_rdata;
    logic [31:0]       rom_masked;
    logic [31:0]       rd_next;
    logic              unused_ofs;

    assign unused_ofs = ^{offset[ADDR_W-1:ROM_AW], offset[0]};

    dmw_region_decode #(
        .ADDR_W(ADDR_W), .ROM_EN(ROM_EN), .EXT_EN(EXT_EN),
        .ROM_SIZE(ROM_SIZE), .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE),
        .MODE_BASE(MODE_BASE), .MODE_SIZE(MODE_SIZE),
        .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE)
    ) u_decode (
        .addr   (h_addr),
        .region (region),
        .offset (offset)
    );

    dmw_legacy_bridge #(
        .LEG_AW(LEG_AW), .PORT_W(PORT_W), .PORT_BASE(PORT_BASE)
    ) u_legacy (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (region == RG_LEG),
        .h_rd        (h_rd),
        .h_wr        (h_wr),
        .h_size      (h_size),
        .ofs         (offset[LEG_AW-1:0]),
        .wdata       (h_wdata[15:0]),
        .lp_addr     (lp_addr),
        .lp_wr       (lp_wr),
        .lp_rd       (lp_rd),
        .lp_wdata    (lp_wdata),
        .lp_rdata_lo (lp_rdata_lo),
        .lp_rdata_hi (lp_rdata_hi),
        .rdata       (leg_rdata)
    );

    dmw_ext_regs #(
        .EXT_AW(EXT_AW), .SIZE_VAL(32'(EXT_SIZE)),
        .BE_CODE(BE_CODE), .LE_CODE(LE_CODE)
    ) u_ext (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (region == RG_EXT),
        .h_wr          (h_wr),
        .h_size        (h_size),
        .ofs           (offset[EXT_AW-1:0]),
        .wdata         (h_wdata),
        .rdata         (ext_rdata),
        .fb_big_endian (fb_big_endian)
    );

    // Mode register file: direct indexing by half-word offset.
    always_comb begin
        mr_index = offset[MIDX_W:1];
        mr_wdata = h_wdata[15:0];
        mr_wr    = (region == RG_MODE) && h_wr;
        mr_rd    = (region == RG_MODE) && h_rd;
    end

    // ROM address and size masking of the returned bytes.
    always_comb begin
        rom_addr = offset[ROM_AW-1:0];
        case (h_size)
            SZ_1:    rom_masked = {24'h0, rom_rdata[7:0]};
            SZ_2:    rom_masked = {16'h0, rom_rdata[15:0]};
            SZ_4:    rom_masked = rom_rdata;
            default: rom_masked = '0;
        endcase
    end

    // Read data select by region.
    always_comb begin
        case (region)
            RG_ROM:  rd_next = rom_masked;
            RG_LEG:  rd_next = {16'h0, leg_rdata};
            RG_MODE: rd_next = {16'h0, mr_rdata};
            RG_EXT:  rd_next = ext_rdata;
            default: rd_next = '0;
        endcase
    end

    // Registered read return with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
        end else begin
            h_rvalid <= h_rd;
            h_rdata  <= h_rd ? rd_next : '0;
        end
    end

    assign revision = EXT_EN ? 8'd2 : BASE_REV;

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> h_rvalid) // R2
        else $error("read without valid pulse");

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !h_rd |=> !h_rvalid) // R2
        else $error("valid without read");

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && (region == RG_NONE)) |=> (h_rdata == 32'h0)) // R11
        else $error("unmapped read returned nonzero");

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_NONE) |-> (!mr_wr && !mr_rd && !lp_rd)) // R11
        else $error("strobe on unmapped offset");

endmodule

// File: tb/disp_mmio_decoder_tb.sv
`timescale 1ns/1ps
// Bench for disp_mmio_decoder. It models the legacy ports, the mode
// registers and the ROM, then walks a vector table and runs directed tests.
module disp_mmio_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_addr = '0;
    logic [1:0]  h_size = '0;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_rvalid;
    logic [9:0]  lp_addr;
    logic        lp_wr, lp_rd;
    logic [7:0]  lp_wdata, lp_rdata_lo, lp_rdata_hi;
    logic [3:0]  mr_index;
    logic        mr_wr, mr_rd;
    logic [15:0] mr_wdata, mr_rdata;
    logic [9:0]  rom_addr;
    logic [31:0] rom_rdata;
    logic        fb_big_endian;
    logic [7:0]  revision;

    always #4 clk = ~clk;

    disp_mmio_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_size(h_size),
        .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_rvalid(h_rvalid), .lp_addr(lp_addr), .lp_wr(lp_wr), .lp_rd(lp_rd),
        .lp_wdata(lp_wdata), .lp_rdata_lo(lp_rdata_lo), .lp_rdata_hi(lp_rdata_hi),
        .mr_index(mr_index), .mr_wr(mr_wr), .mr_rd(mr_rd), .mr_wdata(mr_wdata),
        .mr_rdata(mr_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .fb_big_endian(fb_big_endian), .revision(revision)
    );

    // External models
    logic [7:0]  port_mem [0:31];
    logic [15:0] mode_mem [0:15];
    logic [9:0]  wlog_addr [0:63];
    logic [7:0]  wlog_data [0:63];
    int          wlog_cyc  [0:63];
    int          wlog_n = 0;
    int          cyc = 0;
    int          strobe_cnt = 0;

    function automatic logic [7:0] rom_byte(input logic [9:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign rom_rdata   = {rom_byte(rom_addr + 10'd3), rom_byte(rom_addr + 10'd2),
                          rom_byte(rom_addr + 10'd1), rom_byte(rom_addr)};
    assign lp_rdata_lo = port_mem[lp_addr[4:0]];
    assign lp_rdata_hi = port_mem[lp_addr[4:0] + 5'd1];
    assign mr_rdata    = mode_mem[mr_index];

    initial begin
        for (int i = 0; i < 32; i++) port_mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) mode_mem[i] = 16'h0000;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (lp_wr || lp_rd || mr_wr || mr_rd) strobe_cnt <= strobe_cnt + 1;
        if (lp_wr) begin
            port_mem[lp_addr[4:0]] <= lp_wdata;
            if (wlog_n < 64) begin
                wlog_addr[wlog_n] <= lp_addr;
                wlog_data[wlog_n] <= lp_wdata;
                wlog_cyc[wlog_n]  <= cyc;
                wlog_n            <= wlog_n + 1;
            end
        end
        if (mr_wr) mode_mem[mr_index] <= mr_wdata;
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] got_data;
    logic        got_valid;

    task automatic access(input logic is_rd, input logic [11:0] a,
                          input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        h_addr = a; h_size = sz; h_wdata = wd; h_rd = is_rd; h_wr = !is_rd;
        @(negedge clk);
        h_rd = 1'b0; h_wr = 1'b0;
        got_data  = h_rdata;
        got_valid = h_rvalid;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h404, 2'd0, 32'h0000_0011, 32'h0,          8'd3 },  // R3
        '{1'b1, 12'h404, 2'd0, 32'h0,         32'h0000_0011,  8'd3 },  // R3
        '{1'b0, 12'h410, 2'd1, 32'h0000_A55A, 32'h0,          8'd4 },  // R4
        '{1'b1, 12'h410, 2'd1, 32'h0,         32'h0000_A55A,  8'd5 },  // R5
        '{1'b1, 12'h411, 2'd0, 32'h0,         32'h0000_00A5,  8'd4 },  // R4
        '{1'b1, 12'h404, 2'd2, 32'h0,         32'h0,          8'd3 },  // R3
        '{1'b0, 12'h506, 2'd1, 32'h0000_1234, 32'h0,          8'd6 },  // R6
        '{1'b1, 12'h506, 2'd1, 32'h0,         32'h0000_1234,  8'd6 },  // R6
        '{1'b0, 12'h516, 2'd2, 32'hFFFF_8765, 32'h0,          8'd6 },  // R6
        '{1'b1, 12'h516, 2'd0, 32'h0,         32'h0000_8765,  8'd6 },  // R6
        '{1'b1, 12'h507, 2'd2, 32'h0,         32'h0000_1234,  8'd6 },  // R6
        '{1'b1, 12'h600, 2'd2, 32'h0,         32'h0000_0008,  8'd7 },  // R7
        '{1'b1, 12'h604, 2'd2, 32'h0,         32'h1E1E_1E1E,  8'd8 },  // R8
        '{1'b0, 12'h604, 2'd2, 32'hBEBE_BEBE, 32'h0,          8'd8 },  // R8
        '{1'b1, 12'h604, 2'd2, 32'h0,         32'hBEBE_BEBE,  8'd8 },  // R8
        '{1'b0, 12'h604, 2'd2, 32'h1234_5678, 32'h0,          8'd8 },  // R8
        '{1'b1, 12'h604, 2'd2, 32'h0,         32'hBEBE_BEBE,  8'd8 },  // R8
        '{1'b0, 12'h604, 2'd1, 32'h1E1E_1E1E, 32'h0,          8'd9 },  // R9
        '{1'b1, 12'h604, 2'd2, 32'h0,         32'hBEBE_BEBE,  8'd9 },  // R9
        '{1'b1, 12'h604, 2'd1, 32'h0,         32'h0,          8'd9 },  // R9
        '{1'b1, 12'h601, 2'd2, 32'h0,         32'h0,          8'd9 },  // R9
        '{1'b1, 12'h008, 2'd2, 32'h0,         32'h5150_5352,  8'd10},  // R10
        '{1'b1, 12'h3FF, 2'd0, 32'h0,         32'h0000_00A5,  8'd10},  // R10
        '{1'b1, 12'h001, 2'd1, 32'h0,         32'h0000_585B,  8'd10},  // R10
        '{1'b1, 12'h001, 2'd3, 32'h0,         32'h0,          8'd10},  // R10
        '{1'b0, 12'h008, 2'd2, 32'h0,         32'h0,          8'd10},  // R10
        '{1'b1, 12'h008, 2'd2, 32'h0,         32'h5150_5352,  8'd10},  // R10
        '{1'b1, 12'h700, 2'd2, 32'h0,         32'h0,          8'd11},  // R11
        '{1'b1, 12'h480, 2'd0, 32'h0,         32'h0,          8'd11},  // R11
        '{1'b0, 12'h604, 2'd2, 32'h1E1E_1E1E, 32'h0,          8'd8 }   // R8
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rvalid in reset", {31'h0, h_rvalid}, 32'h0);
        check("R1 flag in reset", {31'h0, fb_big_endian}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid after reset", {31'h0, h_rvalid}, 32'h0);
        check("R1 no strobes idle", {28'h0, lp_wr, lp_rd, mr_wr, mr_rd}, 32'h0);
        check("R12 revision", {24'h0, revision}, 32'h2);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].is_rd, VECS[v].addr, VECS[v].size, VECS[v].wdata);
            if (VECS[v].is_rd) begin
                check($sformatf("R2 valid vec%0d", v), {31'h0, got_valid}, 32'h1);
                check($sformatf("R%0d data vec%0d", VECS[v].req, v), got_data, VECS[v].exp);
            end else begin
                check($sformatf("R2 no valid on write vec%0d", v), {31'h0, got_valid}, 32'h0);
            end
        end
        check("R8 flag back to little", {31'h0, fb_big_endian}, 32'h0);

        // R4: split write order and timing
        begin
            int n0;
            n0 = wlog_n;
            access(1'b0, 12'h41C, 2'd1, 32'h0000_7766);
            check("R4 two port writes", 32'(wlog_n - n0), 32'd2);
            check("R4 low byte first", {14'h0, wlog_addr[n0], wlog_data[n0]}, {14'h0, 10'h3DC, 8'h66});
            check("R4 high byte second", {14'h0, wlog_addr[n0+1], wlog_data[n0+1]}, {14'h0, 10'h3DD, 8'h77});
            check("R4 next cycle", 32'(wlog_cyc[n0+1] - wlog_cyc[n0]), 32'd1);
        end

        // R8: big-endian flag visible at the port
        access(1'b0, 12'h604, 2'd2, 32'hBEBE_BEBE);
        check("R8 flag set", {31'h0, fb_big_endian}, 32'h1);
        access(1'b0, 12'h604, 2'd0, 32'h1E1E_1E1E);
        check("R9 byte write ignored", {31'h0, fb_big_endian}, 32'h1);

        // R11 and R10: writes to unmapped space and ROM raise no strobe
        begin
            int s0;
            s0 = strobe_cnt;
            access(1'b0, 12'h700, 2'd2, 32'hDEAD_BEEF);
            access(1'b0, 12'h480, 2'd0, 32'h0000_00EE);
            access(1'b0, 12'h010, 2'd2, 32'h0000_0000);
            check("R11 no strobes", 32'(strobe_cnt - s0), 32'd0);
        end

        // R3: 4-byte legacy write is dropped
        begin
            int n1;
            n1 = wlog_n;
            access(1'b0, 12'h400, 2'd2, 32'h0000_00FF);
            check("R3 4-byte legacy write dropped", 32'(wlog_n - n1), 32'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule